// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This block takes an external audio codec from power-on to running on its internal PLL as clock master. It holds the codec's active-low power-down line low for a minimum reset pulse, then releases it. It waits for the codec's internal supply to settle, for a length set by a regulator-enable strap. It then issues a short ordered list of register writes through a request/acknowledge port. Only after all of those writes is the PLL power bit written. The block then waits out the worst-case PLL lock time and raises a ready flag.

The serial control bus that carries the writes (I2C or SPI) is not part of this block. A bus master sits behind the write port, takes an address byte and a data byte while `wr_valid_o` is high, and returns `wr_ready_i` in the cycle it accepts them. Every wait is derived from the `CLK_HZ` parameter and rounded up to whole cycles, so each minimum time is always met. The configuration writes come from a packed parameter table. The default table targets 44.1 kHz sampling from an 11.2896 MHz master clock, with a 64fs bit clock and 32-bit I2S framing.

Top module: `codec_pwrup_seq`

## Requirements
- R1: In the cycle after `start_i` is sampled high, `pdn_n_o` is low, `busy_o` is high, `ready_o` is low and `wr_valid_o` is low. `pdn_n_o` then stays low for exactly RST_CYC = max(1, ceil(CLK_HZ x 150 ns)) cycles.
- R2: After `pdn_n_o` rises, `wr_valid_o` stays low for exactly ceil(CLK_HZ x 10 ms) cycles when `ldo_en_i` is 1. It stays low for ceil(CLK_HZ x 1 ms) cycles when `ldo_en_i` is 0. `ldo_en_i` is sampled in the last power-down cycle.
- R3: The configuration writes come out in table order. With the default table they are address 0x01 data 0x08, then address 0x03 data 0x38, then address 0x05 data 0x3A. `wr_addr_o` carries the register address and `wr_data_o` carries the value.
- R4: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values. Each accepted write (valid and ready both high at a clock edge) advances the sequence by exactly one entry.
- R5: The PLL-enable write, address 0x01 data 0x09 (bit 0 set), is issued directly after the last configuration write is accepted, and never before it.
- R6: After the PLL-enable write is accepted, `ready_o` rises after exactly ceil(CLK_HZ x 10 ms) cycles. `busy_o` falls in the same cycle.
- R7: `start_i` restarts the sequence from the power-down state from any state, including in the middle of a write handshake and while ready.
- R8: A low `rst_n` synchronously puts the block in the power-down state, with `pdn_n_o` low, `busy_o` high and no write requested.
- R9: Once ready, the block holds `ready_o` high and `wr_valid_o` low until the next start or reset, whatever `wr_ready_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Restart the whole power-up sequence |
| ldo_en_i | input | 1 | Regulator-enable strap: 1 selects the long settle wait |
| pdn_n_o | output | 1 | Active-low power-down/reset to the codec |
| busy_o | output | 1 | High while the sequence is in progress |
| ready_o | output | 1 | Codec is in normal operation |
| wr_valid_o | output | 1 | Register write request |
| wr_ready_i | input | 1 | Bus master accepts the current write |
| wr_addr_o | output | 8 | Register address of the write |
| wr_data_o | output | 8 | Register value of the write |

## Verification
The bench builds the block with CLK_HZ = 200000, which gives a one-cycle reset pulse, a 200- or 2000-cycle settle wait and a 2000-cycle lock wait. With these values both strap settings and complete sequences fit many times within the run budget, and each wait can be counted to the exact cycle. The default table is kept, so the write order and PLL bit placement are checked against the real configuration values. Random acceptance stalls, together with restarts and resets in the middle of a sequence, exercise the handshake-hold rule and the restart paths.

// File: rtl/pwrup_pkg.sv
// Package: shared state type and time-to-cycle conversion for the codec
// power-up sequencer. Assumes clock frequencies and times fit 64-bit products.
package pwrup_pkg;

    typedef enum logic [2:0] {
        ST_PDN    = 3'd0,
        ST_SETTLE = 3'd1,
        ST_CFG    = 3'd2,
        ST_PLL    = 3'd3,
        ST_LOCK   = 3'd4,
        ST_READY  = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } wr_entry_t;

    // Rounds a duration in ns up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return 32'(c);
    endfunction

endpackage

// File: rtl/seq_timer.sv
// Module: down-counting wait timer. Loading value N-1 makes the owning state
// last exactly N cycles. Assumes load values fit in W bits. INIT is the
// count held during reset so the first wait starts without a load pulse.
module seq_timer #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt;

    // Count register: load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= INIT;
        else if (load_i)
            cnt <= load_val_i;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Expiry flag: the wait is over once the counter has reached zero.
    always_comb expired_o = (cnt == '0);

    // The counter moves down by exactly one per unloaded cycle (R2, R6 timing base).
    p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/seq_write_port.sv
// Module: issues the configuration table and then the PLL-enable write over
// a valid/ready port. Assumes CFG_COUNT >= 1 and that cfg and pll phases are
// never requested together. Entry i of CFG_TABLE is bits [16*i +: 16],
// with the address in the upper byte.
module seq_write_port
    import pwrup_pkg::*;
#(
    parameter int unsigned CFG_COUNT = 3,
    parameter logic [CFG_COUNT*16-1:0] CFG_TABLE = {16'h053A, 16'h0338, 16'h0108},
    parameter logic [7:0] PLL_ADDR = 8'h01,
    parameter logic [7:0] PLL_DATA = 8'h09
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       cfg_phase_i,
    input  logic       pll_phase_i,
    input  logic       wr_ready_i,
    output logic       wr_valid_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       cfg_done_o,
    output logic       pll_done_o
);
    localparam int unsigned IW = $clog2(CFG_COUNT + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(CFG_COUNT - 1);
    localparam logic [IW-1:0] END_IDX  = IW'(CFG_COUNT);

    wr_entry_t    table_q [CFG_COUNT];
    wr_entry_t    cur;
    logic [IW-1:0] idx;
    logic          accept;

    // Unpack the flat parameter table into one entry per configuration write.
    for (genvar i = 0; i < CFG_COUNT; i++) begin : g_table
        assign table_q[i] = wr_entry_t'(CFG_TABLE[16*i +: 16]);
    end

    // Select the entry to present: the PLL write in its phase, else the table slot.
    always_comb begin
        if (pll_phase_i)
            cur = '{addr: PLL_ADDR, data: PLL_DATA};
        else if (idx < END_IDX)
            cur = table_q[idx];
        else
            cur = '0;
    end

    // Handshake outputs and completion pulses.
    always_comb begin
        wr_valid_o = cfg_phase_i || pll_phase_i;
        wr_addr_o  = cur.addr;
        wr_data_o  = cur.data;
        accept     = wr_valid_o && wr_ready_i;
        cfg_done_o = cfg_phase_i && wr_ready_i && (idx == LAST_IDX);
        pll_done_o = pll_phase_i && wr_ready_i;
    end

    // Table index: one step per accepted configuration write, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            idx <= '0;
        else if (cfg_phase_i && accept && idx < END_IDX)
            idx <= idx + 1'b1;
    end

    // A pending request keeps its address and data until accepted.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // The PLL write is requested only when every table entry has been consumed.
    p_pll_after_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_phase_i |-> (idx == END_IDX));

    // Each accepted configuration write moves the index by exactly one.
    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
        (cfg_phase_i && accept) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/codec_pwrup_seq.sv
// Module: top of the codec power-up sequencer. Orders reset pulse, supply
// settle, configuration writes, PLL enable and lock wait; all waits derive
// from CLK_HZ and round up. Assumes start_i and ldo_en_i are synchronous.
module codec_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter longint unsigned CLK_HZ          = 50_000_000,
    parameter longint unsigned T_RST_NS        = 150,
    parameter longint unsigned T_SETTLE_LDO_NS = 10_000_000,
    parameter longint unsigned T_SETTLE_EXT_NS = 1_000_000,
    parameter longint unsigned T_LOCK_NS       = 10_000_000,
    parameter int unsigned     CFG_COUNT       = 3,
    parameter logic [CFG_COUNT*16-1:0] CFG_TABLE = {16'h053A, 16'h0338, 16'h0108},
    parameter logic [7:0]      PLL_ADDR        = 8'h01,
    parameter logic [7:0]      PLL_DATA        = 8'h09
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ldo_en_i,
    output logic       pdn_n_o,
    output logic       busy_o,
    output logic       ready_o,
    output logic       wr_valid_o,
    input  logic       wr_ready_i,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o
);
    localparam int unsigned RST_CYC   = ns_to_cycles(CLK_HZ, T_RST_NS);
    localparam int unsigned LDO_CYC   = ns_to_cycles(CLK_HZ, T_SETTLE_LDO_NS);
    localparam int unsigned EXT_CYC   = ns_to_cycles(CLK_HZ, T_SETTLE_EXT_NS);
    localparam int unsigned LOCK_CYC  = ns_to_cycles(CLK_HZ, T_LOCK_NS);
    localparam int unsigned MAX_A     = (LDO_CYC > EXT_CYC) ? LDO_CYC : EXT_CYC;
    localparam int unsigned MAX_B     = (LOCK_CYC > RST_CYC) ? LOCK_CYC : RST_CYC;
    localparam int unsigned MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW        = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] RST_LD  = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] LDO_LD  = TW'(LDO_CYC - 1);
    localparam logic [TW-1:0] EXT_LD  = TW'(EXT_CYC - 1);
    localparam logic [TW-1:0] LOCK_LD = TW'(LOCK_CYC - 1);

    seq_state_t    state, state_nxt;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          cfg_done, pll_done;

    // Wait timer shared by the reset, settle and lock phases.
    seq_timer #(.W(TW), .INIT(RST_LD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    // Register write issuer for the table and the PLL-enable write.
    seq_write_port #(
        .CFG_COUNT (CFG_COUNT),
        .CFG_TABLE (CFG_TABLE),
        .PLL_ADDR  (PLL_ADDR),
        .PLL_DATA  (PLL_DATA)
    ) u_wport (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .cfg_phase_i (state == ST_CFG),
        .pll_phase_i (state == ST_PLL),
        .wr_ready_i  (wr_ready_i),
        .wr_valid_o  (wr_valid_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o),
        .cfg_done_o  (cfg_done),
        .pll_done_o  (pll_done)
    );

    // Next-state and timer-load decisions; start overrides every state.
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        if (start_i) begin
            state_nxt = ST_PDN;
            tmr_load  = 1'b1;
            tmr_val   = RST_LD;
        end else begin
            unique case (state)
                ST_PDN: if (tmr_expired) begin
                    state_nxt = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = ldo_en_i ? LDO_LD : EXT_LD;
                end
                ST_SETTLE: if (tmr_expired) state_nxt = ST_CFG;
                ST_CFG:    if (cfg_done)    state_nxt = ST_PLL;
                ST_PLL: if (pll_done) begin
                    state_nxt = ST_LOCK;
                    tmr_load  = 1'b1;
                    tmr_val   = LOCK_LD;
                end
                ST_LOCK:   if (tmr_expired) state_nxt = ST_READY;
                ST_READY:  state_nxt = ST_READY;
                default:   state_nxt = ST_PDN;
            endcase
        end
    end

    // State register with synchronous reset into power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_PDN;
        else
            state <= state_nxt;
    end

    // Status outputs decoded from the state register.
    always_comb begin
        pdn_n_o = (state != ST_PDN);
        ready_o = (state == ST_READY);
        busy_o  = (state != ST_READY);
    end

    // No register write while the codec is held in power-down.
    p_no_write_in_pdn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> pdn_n_o);

    // Ready is entered only from the lock wait.
    p_ready_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(state) == ST_LOCK));

    // Ready holds until a restart and requests nothing.
    p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i) |=> (ready_o && !wr_valid_o));

    // A start always lands in power-down on the next cycle.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!pdn_n_o && !wr_valid_o));

endmodule

// File: tb/sim_codec_pwrup_seq.sv
`timescale 1ns/1ps
module sim_codec_pwrup_seq;
    localparam longint unsigned HZ = 200_000;

    function automatic int cyc(longint unsigned ns);
        longint unsigned c;
        c = (HZ * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 1 : int'(c);
    endfunction

    function automatic logic [7:0] exp_addr(int k);
        case (k)
            0: return 8'h01;
            1: return 8'h03;
            2: return 8'h05;
            default: return 8'h01;
        endcase
    endfunction

    function automatic logic [7:0] exp_data(int k);
        case (k)
            0: return 8'h08;
            1: return 8'h38;
            2: return 8'h3A;
            default: return 8'h09;
        endcase
    endfunction

    logic clk = 0, rst_n = 0, start = 0, ldo_en = 0, wr_ready = 0;
    logic pdn_n, busy, ready, wr_valid;
    logic [7:0] wr_addr, wr_data;
    int n_chk = 0, n_err = 0;
    int cyc_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    codec_pwrup_seq #(.CLK_HZ(HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ldo_en_i(ldo_en),
        .pdn_n_o(pdn_n), .busy_o(busy), .ready_o(ready),
        .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150_000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc_cnt);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic pulse_start();
        start = 1;
        @(negedge clk);
        start = 0;
        chk(!pdn_n && busy && !ready && !wr_valid, "R1", "state after start",
            {pdn_n, busy, ready, wr_valid}, 4'b0100);
    endtask

    task automatic follow_seq(input int stall);
        int n, s, l;
        bit r;
        n = 0;
        while (!pdn_n && n < 100) begin n++; wr_ready = $urandom % 2; @(negedge clk); end
        chk(n == cyc(150), "R1", "pdn low cycles", n, cyc(150));
        s = 0;
        while (!wr_valid && s < 5000) begin s++; wr_ready = $urandom % 2; @(negedge clk); end
        chk(s == (ldo_en ? cyc(10_000_000) : cyc(1_000_000)), "R2", "settle cycles",
            s, ldo_en ? cyc(10_000_000) : cyc(1_000_000));
        for (int k = 0; k < 4; k++) begin
            chk(wr_valid && wr_addr == exp_addr(k) && wr_data == exp_data(k),
                (k < 3) ? "R3" : "R5", "write entry", {wr_valid, wr_addr, wr_data},
                {1'b1, exp_addr(k), exp_data(k)});
            for (int t = 0; t < 200; t++) begin
                r = (($urandom % 100) >= stall) || (t == 199);
                wr_ready = r;
                @(negedge clk);
                if (r) break;
                chk(wr_valid && wr_addr == exp_addr(k) && wr_data == exp_data(k), "R4",
                    "hold while stalled", {wr_valid, wr_addr, wr_data},
                    {1'b1, exp_addr(k), exp_data(k)});
            end
            wr_ready = 0;
        end
        l = 0;
        while (!ready && l < 5000) begin
            if (wr_valid) chk(0, "R6", "write during lock", 1, 0);
            l++; wr_ready = $urandom % 2; @(negedge clk);
        end
        chk(l == cyc(10_000_000), "R6", "lock cycles", l, cyc(10_000_000));
        chk(!busy, "R6", "busy at ready", busy, 0);
        for (int i = 0; i < 6; i++) begin
            wr_ready = $urandom % 2;
            @(negedge clk);
            chk(ready && !wr_valid && !busy, "R9", "ready hold", {ready, wr_valid, busy}, 3'b100);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!pdn_n && busy && !ready && !wr_valid, "R8", "reset state",
            {pdn_n, busy, ready, wr_valid}, 4'b0100);
        rst_n = 1;
        @(negedge clk);
        // Directed: long settle no stalls, short settle heavy stalls.
        ldo_en = 1; pulse_start(); follow_seq(0);
        ldo_en = 0; pulse_start(); follow_seq(70);
        // Random runs; each start also restarts from the ready state (R7).
        for (int i = 0; i < 5; i++) begin
            ldo_en = $urandom % 2;
            pulse_start();
            follow_seq($urandom % 80);
        end
        // Restart in the middle of a stalled handshake (R7).
        ldo_en = 0; pulse_start();
        for (int i = 0; i < 2000 && !wr_valid; i++) begin wr_ready = 0; @(negedge clk); end
        repeat (3) @(negedge clk);
        chk(wr_valid && wr_addr == 8'h01, "R7", "stalled first write", {wr_valid, wr_addr}, 9'h101);
        pulse_start();
        chk(!pdn_n && !wr_valid, "R7", "restart mid-write", {pdn_n, wr_valid}, 2'b00);
        follow_seq(30);
        // Synchronous reset in the middle of the settle wait (R8).
        ldo_en = 1; pulse_start();
        repeat (50) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(!pdn_n && busy && !ready && !wr_valid, "R8", "reset mid-settle",
            {pdn_n, busy, ready, wr_valid}, 4'b0100);
        rst_n = 1;
        @(negedge clk);
        pulse_start(); follow_seq(20);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule